// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers eight asynchronous interrupt request lines and two timer time-out events into one prioritised request toward a processor. Each of the ten sources has a programmable 3-bit priority level. Software can mask any source on its own, and each timer event can be enabled or disabled. Edges on the inputs are latched as pending bits. The highest eligible level is encoded onto three processor pins. A fourth pin raises a request whenever that code is non-zero. A fifth pin carries a non-maskable interrupt that bypasses all masking and priority logic.

The processor answers with an acknowledge strobe. During that strobe the block presents the vector number of the winning source, and it clears that source's pending bit on the same clock edge. Software configures the block through a small register port with the following registers: level maps, mask, timer enables, and a pending register that is read directly and cleared by writing 1s.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, cpu_lvl_o, cpu_req_o and cpu_nmi_o are 0, all pending bits are 0, all levels are 0, the mask register reads 0x3FF (every source masked), timer enables are 0, and vector_o shows the spurious vector 0xFF.
- R2: An external input passes through a two-flop synchroniser. A pending bit is set only on a rising edge of the synchronised input. An input that is held high does not set the bit again after it has been cleared.
- R3: cpu_lvl_o is one clock behind the pending state. It carries the highest level among sources that are pending, unmasked and have a non-zero level, and 0 when no source qualifies. A source whose level is 0 never requests.
- R4: Among eligible sources that share the highest level, the source with the lower index wins. Sources 0 to 7 are the external inputs and sources 8 and 9 are timers 0 and 1.
- R5: cpu_req_o is 1 exactly when cpu_lvl_o is non-zero.
- R6: A masked source still latches its pending bit but does not request. Clearing its mask bit lets its level appear.
- R7: cpu_nmi_o follows nmi_i through a two-flop synchroniser, whatever the mask and level settings are.
- R8: A timer event pulse sets that timer's pending bit only when the timer's enable bit is 1. Otherwise the pulse is ignored.
- R9: While iack_i is high, vector_o = 0x40 + winning source index, and the winner's pending bit clears at the next clock edge. With no eligible source, vector_o = 0xFF and no bit is cleared.
- R10: A write to the pending register (address 4) clears every pending bit whose data bit is 1 and leaves the others unchanged.
- R11: Register map, read back on reg_rdata_o combinationally from reg_addr_i. Address 0 holds the levels of sources 0–7, with source i in bits 4i+2..4i. Address 1 holds the levels of sources 8–9 in the same nibble layout. Address 2 holds the mask in bits 9:0, where 1 means masked. Address 3 holds the timer enables in bits 1:0. The fourth bit of each nibble reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_irq_i | input | 8 | Asynchronous external interrupt requests |
| nmi_i | input | 1 | Asynchronous non-maskable request |
| tmr_evt_i | input | 2 | Synchronous one-cycle timer time-out pulses |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| iack_i | input | 1 | Interrupt acknowledge strobe |
| vector_o | output | 8 | Vector of the winning source |
| cpu_lvl_o | output | 3 | Encoded highest pending level |
| cpu_req_o | output | 1 | Request strobe, high while level is non-zero |
| cpu_nmi_o | output | 1 | Non-maskable interrupt pin |

## Verification
The bench sweeps every source through every non-zero level. It then fills all ten pending bits with a level pattern that contains three ties and acknowledges them one by one, checking each winner against a model held in the bench. A tie broken toward the higher index, or a level compared with the wrong sense, shows up as a wrong vector at some step of this drain.

Further checks cover the following cases:
- An input held high after acknowledge must not re-arm. An edge detector that is level-sensitive instead would leave the bit pending.
- A masked source must keep its pending bit.
- Disabled timers must ignore their events.
- The write-1-to-clear register must leave bits untouched where the data is 0.
- The acknowledge of a level-0 source must return the spurious vector and clear nothing.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned LVL_W  = 3;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_LVL_LO = 3'd0,
    REG_LVL_HI = 3'd1,
    REG_MASK   = 3'd2,
    REG_TMR_EN = 3'd3,
    REG_PEND   = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int unsigned N_EXT = 8,
  parameter int unsigned N_TMR = 2,
  localparam int unsigned N_SRC = N_EXT + N_TMR
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EXT-1:0] ext_s_i,
  input  logic [N_TMR-1:0] tmr_evt_i,
  input  logic [N_TMR-1:0] tmr_en_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] set_o,
  output logic [N_SRC-1:0] pend_o
);
  logic [N_EXT-1:0] ext_d_q;
  logic [N_SRC-1:0] pend_q;

  assign set_o = {tmr_evt_i & tmr_en_i, ext_s_i & ~ext_d_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_d_q <= '0;
      pend_q  <= '0;
    end else begin
      ext_d_q <= ext_s_i;
      // a new edge wins over a clear in the same cycle
      pend_q  <= (pend_q & ~clr_i) | set_o;
    end
  end

  assign pend_o = pend_q;

  for (genvar i = 0; i < N_EXT; i++) begin : g_ext_chk
    a_r2_set_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pend_q[i]) |-> $past(ext_s_i[i] && !ext_d_q[i]));
  end

  for (genvar k = 0; k < N_TMR; k++) begin : g_tmr_chk
    a_r8_tmr_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pend_q[N_EXT+k]) |-> $past(tmr_evt_i[k] && tmr_en_i[k]));
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned N_SRC = 10,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]            pend_i,
  input  logic [N_SRC-1:0]            mask_i,
  input  logic [N_SRC-1:0][LVL_W-1:0] lvl_i,
  output logic                        win_valid_o,
  output logic [IDX_W-1:0]            win_idx_o,
  output logic [LVL_W-1:0]            win_lvl_o
);
  always_comb begin
    win_lvl_o = '0;
    win_idx_o = '0;
    // ascending scan with strict compare keeps the lowest index on ties
    for (int i = 0; i < N_SRC; i++) begin
      if (pend_i[i] && !mask_i[i] && (lvl_i[i] > win_lvl_o)) begin
        win_lvl_o = lvl_i[i];
        win_idx_o = IDX_W'(i);
      end
    end
    win_valid_o = (win_lvl_o != '0);
  end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned N_SRC = 10,
  parameter int unsigned N_TMR = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  input  logic [N_SRC-1:0]            pend_i,
  output logic [N_SRC-1:0][LVL_W-1:0] lvl_o,
  output logic [N_SRC-1:0]            mask_o,
  output logic [N_TMR-1:0]            tmr_en_o,
  output logic [N_SRC-1:0]            w1c_o,
  output logic [DATA_W-1:0]           rdata_o
);
  localparam int unsigned NIB = 4;
  localparam int unsigned PER_REG = DATA_W / NIB;

  logic [N_SRC-1:0][LVL_W-1:0] lvl_q;
  logic [N_SRC-1:0]            mask_q;
  logic [N_TMR-1:0]            tmr_en_q;
  logic [1:0][DATA_W-1:0]      lvl_img;
  logic                        unused_wdata;

  assign unused_wdata = ^wdata_i;

  for (genvar i = 0; i < N_SRC; i++) begin : g_lvl
    localparam int unsigned SEL = i / PER_REG;
    localparam int unsigned OFS = NIB * (i % PER_REG);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 lvl_q[i] <= '0;
      else if (wr_i && addr_i == ADDR_W'(SEL))     lvl_q[i] <= wdata_i[OFS +: LVL_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q   <= '1;
      tmr_en_q <= '0;
    end else if (wr_i) begin
      if (addr_i == REG_MASK)   mask_q   <= wdata_i[N_SRC-1:0];
      if (addr_i == REG_TMR_EN) tmr_en_q <= wdata_i[N_TMR-1:0];
    end
  end

  always_comb begin
    lvl_img = '0;
    for (int i = 0; i < N_SRC; i++) begin
      lvl_img[i/PER_REG][NIB*(i%PER_REG) +: LVL_W] = lvl_q[i];
    end
  end

  always_comb begin
    case (addr_i)
      REG_LVL_LO: rdata_o = lvl_img[0];
      REG_LVL_HI: rdata_o = lvl_img[1];
      REG_MASK:   rdata_o = DATA_W'(mask_q);
      REG_TMR_EN: rdata_o = DATA_W'(tmr_en_q);
      REG_PEND:   rdata_o = DATA_W'(pend_i);
      default:    rdata_o = '0;
    endcase
  end

  assign w1c_o    = (wr_i && addr_i == REG_PEND) ? wdata_i[N_SRC-1:0] : '0;
  assign lvl_o    = lvl_q;
  assign mask_o   = mask_q;
  assign tmr_en_o = tmr_en_q;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned N_EXT    = 8,
  parameter int unsigned N_TMR    = 2,
  parameter logic [7:0]  VEC_BASE = 8'h40,
  parameter logic [7:0]  SPUR_VEC = 8'hFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_EXT-1:0]  ext_irq_i,
  input  logic              nmi_i,
  input  logic [N_TMR-1:0]  tmr_evt_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              iack_i,
  output logic [7:0]        vector_o,
  output logic [LVL_W-1:0]  cpu_lvl_o,
  output logic              cpu_req_o,
  output logic              cpu_nmi_o
);
  localparam int unsigned N_SRC = N_EXT + N_TMR;
  localparam int unsigned IDX_W = $clog2(N_SRC);

  logic [N_EXT-1:0]            ext_s;
  logic [N_SRC-1:0]            pend, set_vec, clr_vec, w1c, mask;
  logic [N_SRC-1:0][LVL_W-1:0] lvl;
  logic [N_TMR-1:0]            tmr_en;
  logic                        win_valid;
  logic [IDX_W-1:0]            win_idx;
  logic [LVL_W-1:0]            win_lvl, lvl_q;
  logic                        req_q;

  irq_sync #(.W(N_EXT)) u_ext_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ext_irq_i), .q_o(ext_s)
  );

  irq_sync #(.W(1)) u_nmi_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(nmi_i), .q_o(cpu_nmi_o)
  );

  irq_pending #(.N_EXT(N_EXT), .N_TMR(N_TMR)) u_pend (
    .clk_i(clk_i), .rst_ni(rst_ni), .ext_s_i(ext_s), .tmr_evt_i(tmr_evt_i),
    .tmr_en_i(tmr_en), .clr_i(clr_vec), .set_o(set_vec), .pend_o(pend)
  );

  irq_regs #(.N_SRC(N_SRC), .N_TMR(N_TMR)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .pend_i(pend), .lvl_o(lvl), .mask_o(mask),
    .tmr_en_o(tmr_en), .w1c_o(w1c), .rdata_o(reg_rdata_o)
  );

  irq_arbiter #(.N_SRC(N_SRC)) u_arb (
    .pend_i(pend), .mask_i(mask), .lvl_i(lvl),
    .win_valid_o(win_valid), .win_idx_o(win_idx), .win_lvl_o(win_lvl)
  );

  always_comb begin
    clr_vec = w1c;
    if (iack_i && win_valid) clr_vec[win_idx] = 1'b1;
  end

  assign vector_o = win_valid ? (VEC_BASE + 8'(win_idx)) : SPUR_VEC;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
      req_q <= 1'b0;
    end else begin
      lvl_q <= win_lvl;
      req_q <= win_valid;
    end
  end

  assign cpu_lvl_o = lvl_q;
  assign cpu_req_o = req_q;

  a_r5_req_tracks_lvl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_o == (cpu_lvl_o != '0));

  a_r3_lvl_needs_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_lvl_o != '0) |-> $past(|(pend & ~mask)));

  a_r9_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iack_i && win_valid && !set_vec[win_idx]) |=> !pend[$past(win_idx)]);

  a_r7_nmi_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_nmi_o) |-> $past(nmi_i, 2));
endmodule

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  ext = '0;
  logic        nmi = 1'b0;
  logic [1:0]  tevt = '0;
  logic        wr = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        iack = 1'b0;
  logic [7:0]  vec;
  logic [2:0]  lvl;
  logic        req, nmi_o;

  int checks = 0, errors = 0;
  bit done = 0;
  int b_lvl [10];
  logic [9:0] b_pend;

  always #2.5 clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ext_irq_i(ext), .nmi_i(nmi), .tmr_evt_i(tevt),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .iack_i(iack), .vector_o(vec), .cpu_lvl_o(lvl), .cpu_req_o(req), .cpu_nmi_o(nmi_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); addr = a; #0.5;
    chk(rdata == exp, tag, rdata, exp);
  endtask

  task automatic write_levels();
    logic [31:0] lo = '0, hi = '0;
    for (int i = 0; i < 8; i++) lo |= 32'(b_lvl[i]) << (4*i);
    hi = 32'(b_lvl[8]) | (32'(b_lvl[9]) << 4);
    wreg(3'd0, lo);
    wreg(3'd1, hi);
  endtask

  // winner from bench model: highest level, lowest index on ties
  function automatic int exp_win(input logic [9:0] p);
    int best = 0, idx = -1;
    for (int i = 0; i < 10; i++)
      if (p[i] && b_lvl[i] > best) begin best = b_lvl[i]; idx = i; end
    return idx;
  endfunction

  // iack for one cycle; vector sampled mid-cycle; returns after level reg updated
  task automatic do_ack(input int exp_vec, input string tag);
    @(negedge clk); iack = 1'b1; #0.5;
    chk(vec == 8'(exp_vec), tag, vec, exp_vec);
    @(negedge clk); iack = 1'b0;
    @(negedge clk);
  endtask

  task automatic fire(input int s);
    if (s < 8) begin
      @(negedge clk); ext[s] = 1'b1;
      repeat (5) @(negedge clk);
    end else begin
      @(negedge clk); tevt[s-8] = 1'b1;
      @(negedge clk); tevt = '0;
      repeat (2) @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(lvl == 0, "R1 lvl", lvl, 0);
    chk(req == 0, "R1 req", req, 0);
    chk(nmi_o == 0, "R1 nmi", nmi_o, 0);
    chk(vec == 8'hFF, "R1 vector", vec, 8'hFF);
    rreg(3'd4, 32'h0, "R1 pend");
    rreg(3'd2, 32'h3FF, "R1 mask");
    rreg(3'd0, 32'h0, "R1 lvl_lo");
    rreg(3'd3, 32'h0, "R1 tmr_en");

    // R11 register readback
    wreg(3'd0, 32'h7654_3210); rreg(3'd0, 32'h7654_3210, "R11 lvl_lo");
    wreg(3'd1, 32'hFFFF_FFFF); rreg(3'd1, 32'h0000_0077, "R11 lvl_hi");
    wreg(3'd2, 32'h0000_0155); rreg(3'd2, 32'h0000_0155, "R11 mask");
    wreg(3'd3, 32'h0000_0003); rreg(3'd3, 32'h0000_0003, "R11 tmr_en");

    // R3 R5 R9 R2: each source at each level alone
    wreg(3'd2, 32'h0);
    for (int s = 0; s < 10; s++) begin
      for (int l = 1; l < 8; l++) begin
        for (int i = 0; i < 10; i++) b_lvl[i] = 0;
        b_lvl[s] = l;
        write_levels();
        fire(s);
        chk(lvl == 3'(l), "R3 single level", lvl, l);
        chk(req == 1'b1, "R5 req high", req, 1);
        do_ack(8'h40 + s, "R9 single vector");
        chk(lvl == 0 && req == 0, "R5 idle after ack", {lvl, req}, 0);
        repeat (2) @(negedge clk);
        rreg(3'd4, 32'h0, "R2 held input does not re-pend");
        ext = '0;
        repeat (3) @(negedge clk);
      end
    end

    // R4 R3: all sources pending, drained by acknowledge
    for (int i = 0; i < 10; i++) b_lvl[i] = ((i*5) % 7) + 1;
    write_levels();
    @(negedge clk); ext = 8'hFF; tevt = 2'b11;
    @(negedge clk); tevt = '0;
    repeat (5) @(negedge clk);
    b_pend = 10'h3FF;
    rreg(3'd4, 32'h3FF, "R2 all pending");
    while (b_pend != 0) begin
      int w;
      w = exp_win(b_pend);
      chk(lvl == 3'(b_lvl[w]), "R3 drain level", lvl, b_lvl[w]);
      do_ack(8'h40 + w, "R4 drain vector");
      b_pend[w] = 1'b0;
    end
    chk(lvl == 0, "R3 drained", lvl, 0);
    ext = '0;
    repeat (3) @(negedge clk);

    // R6 mask keeps pending
    for (int i = 0; i < 10; i++) b_lvl[i] = 0;
    b_lvl[3] = 5;
    write_levels();
    wreg(3'd2, 32'h008);
    fire(3);
    chk(lvl == 0 && req == 0, "R6 masked silent", {lvl, req}, 0);
    rreg(3'd4, 32'h008, "R6 masked still pending");
    wreg(3'd2, 32'h0);
    repeat (2) @(negedge clk);
    chk(lvl == 5, "R6 unmasked level", lvl, 5);
    do_ack(8'h43, "R6 vector");
    ext = '0;

    // R3 R9 level-0 source never requests; spurious ack clears nothing
    fire(6);
    chk(lvl == 0, "R3 level0 no request", lvl, 0);
    do_ack(8'hFF, "R9 spurious vector");
    rreg(3'd4, 32'h040, "R9 spurious keeps pending");
    wreg(3'd4, 32'h040);
    ext = '0;

    // R8 disabled timers ignore events
    b_lvl[8] = 7; b_lvl[9] = 7;
    write_levels();
    wreg(3'd3, 32'h0);
    fire(8); fire(9);
    rreg(3'd4, 32'h0, "R8 disabled timer ignored");
    chk(lvl == 0, "R8 no level", lvl, 0);
    wreg(3'd3, 32'h2);
    fire(8); fire(9);
    rreg(3'd4, 32'h200, "R8 only enabled timer pends");
    wreg(3'd4, 32'h200);

    // R10 write-1-to-clear
    wreg(3'd2, 32'h3FF);
    @(negedge clk); ext = 8'h0F;
    repeat (5) @(negedge clk);
    rreg(3'd4, 32'h00F, "R10 setup");
    wreg(3'd4, 32'h005); rreg(3'd4, 32'h00A, "R10 partial clear");
    wreg(3'd4, 32'h000); rreg(3'd4, 32'h00A, "R10 zero write keeps");
    wreg(3'd4, 32'h00A); rreg(3'd4, 32'h000, "R10 full clear");
    ext = '0;

    // R7 NMI bypasses masking
    @(negedge clk); nmi = 1'b1;
    @(negedge clk); #0.5;
    chk(nmi_o == 0, "R7 nmi sync latency", nmi_o, 0);
    @(negedge clk); #0.5;
    chk(nmi_o == 1, "R7 nmi asserted", nmi_o, 1);
    chk(lvl == 0, "R7 nmi not coded", lvl, 0);
    nmi = 1'b0;
    repeat (3) @(negedge clk);
    chk(nmi_o == 0, "R7 nmi released", nmi_o, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule